// File: doc/BRIEF.md
# Per-Stream Output Lead Serializer

This block turns parallel channel bytes into time-division-multiplexed serial output streams at 8 Mbps. It runs from a 131.072 MHz system clock, so each serial bit lasts 16 system clocks. Every output stream has its own 2-bit lead code. The code moves that stream's whole bit timing earlier than the nominal timing by 0, 2, 4 or 6 system clocks, so that streams with heavier pin loading can be sent out ahead. This is about 0, 15, 31 or 46 ns.

The streams form two banks of equal kind, a local bank and a backplane bank. A single-cycle frame strobe sets the frame phase. A free-running frame counter restarts from that strobe, and each stream reads the counter plus its own lead. For each byte it needs, a stream raises a one-cycle request and reports the channel number. The parallel source places that channel's byte on the stream's byte input in the same cycle. A write to a lead code is held in a pending register and applied at the next frame strobe. The timing therefore never moves in the middle of a frame.

Top module: `tdm_out_lead`

## Requirements
- R1: Each stream has its own lead code. `cfg_bank`=0 selects the local bank and 1 selects the backplane bank, and `cfg_idx` selects the stream within that bank. A write changes only the addressed stream.
- R2: Code 00 gives a lead of 0 cycles, 01 gives 2, 10 gives 4 and 11 gives 6. Let frame cycle c=0 be the first cycle after the strobe is sampled. In cycle c, a stream with lead L shows the bit at frame position p=(c+L) mod F, with F=CHANNELS*128. That bit belongs to channel p/128 and is bit 7-((p/16) mod 8) of that channel's byte.
- R3: Each bit lasts 16 cycles and is sent most significant bit first, with channels 0 to CHANNELS-1 in order. With lead L, channel 0 bit 7 first appears L cycles before frame cycle 0. The bit before it (the last channel, bit 0) is present in the cycle just before that.
- R4: A frame strobe always restarts the frame count at cycle 0, even when it comes early. One full frame later, every stream is aligned to the new phase.
- R5: After reset, every lead code is 00, and all serial outputs and byte requests are low.
- R6: A code written during a frame has no effect on output timing until the next frame strobe. From the frame that strobe starts, the new code governs.
- R7: The byte request of a stream is high for exactly the one cycle in which p mod 128 = 127. In that cycle, the request channel output gives (p+1)/128 mod CHANNELS, and the byte input is taken as that channel's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 131.072 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | One-cycle output frame strobe |
| cfg_we | input | 1 | Lead code write enable |
| cfg_bank | input | 1 | Bank select: 0 local, 1 backplane |
| cfg_idx | input | IDX_W | Stream index within the bank |
| cfg_code | input | 2 | Lead code to write |
| lcl_byte | input | N_LCL*8 | Channel bytes for local streams, 8 bits per stream |
| bp_byte | input | N_BP*8 | Channel bytes for backplane streams, 8 bits per stream |
| lcl_ser | output | N_LCL | Local serial outputs |
| bp_ser | output | N_BP | Backplane serial outputs |
| lcl_req | output | N_LCL | Local byte request strobes |
| bp_req | output | N_BP | Backplane byte request strobes |
| lcl_req_chan | output | N_LCL*CH_W | Channel number for each local request |
| bp_req_chan | output | N_BP*CH_W | Channel number for each backplane request |

## Verification
Serialization is first tried with every stream at the default code. It is then tried with the two banks set to opposite staircases of codes, which would expose a swap between banks or a wrong code-to-lead mapping. Random code writes at random points in the frame separate the stream that was written from its neighbours, and separate the held pending value from the applied one. An early frame strobe shows that the block follows the new phase rather than running on with its own count. Channel data are random, with the bits at the frame edge forced to opposite values. This makes the cycle of the first transition visible for each lead.

// File: rtl/tdm_lead_pkg.sv
package tdm_lead_pkg;

   typedef logic [1:0] lead_code_t;

   localparam int BITS_PER_BYTE = 8;

   // Lead in system clocks for a code and a step size.
   function automatic int lead_cycles(lead_code_t code, int step);
      return int'(code) * step;
   endfunction

endpackage

// File: rtl/tdm_lead_frame_ctr.sv
module tdm_lead_frame_ctr #(
   parameter int POS_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_pulse,
   output logic [POS_W-1:0] cnt_q,
   output logic [POS_W-1:0] cnt_next
);

   // The frame length is a power of two, so the count wraps by itself.
   always_comb begin
      if (frame_pulse) cnt_next = '0;
      else             cnt_next = cnt_q + POS_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_next;
   end

endmodule

// File: rtl/tdm_lead_cfg_bank.sv
module tdm_lead_cfg_bank
   import tdm_lead_pkg::*;
#(
   parameter int N     = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_pulse,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  lead_code_t       wr_code,
   output logic [2*N-1:0]   act_flat,
   output logic [2*N-1:0]   eff_flat
);

   for (genvar i = 0; i < N; i++) begin : g_slot
      lead_code_t pend_q;
      lead_code_t act_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
         end else begin
            if (wr_en && wr_idx == IDX_W'(i)) pend_q <= wr_code;
            if (frame_pulse)                  act_q  <= pend_q;
         end
      end

      // On the strobe edge the serializer already uses the new value.
      assign eff_flat[2*i +: 2] = frame_pulse ? pend_q : act_q;
      assign act_flat[2*i +: 2] = act_q;
   end

endmodule

// File: rtl/tdm_lead_serializer.sv
module tdm_lead_serializer
   import tdm_lead_pkg::*;
#(
   parameter int POS_W     = 14,
   parameter int BIT_SH    = 4,
   parameter int CH_W      = 7,
   parameter int LEAD_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_pulse,
   input  logic [POS_W-1:0] cnt_next,
   input  lead_code_t       code,
   input  logic [7:0]       tx_byte,
   output logic             ser_q,
   output logic             req_q,
   output logic [CH_W-1:0]  req_chan_q
);

   localparam int SLOT_W = BIT_SH + 3;

   logic [POS_W-1:0] lead_cyc;
   logic [POS_W-1:0] pos_next;
   logic [2:0]       bit_sel;
   logic             at_bit;
   logic             last_slot;
   logic [7:0]       byte_q;
   logic [7:0]       src_byte;

   assign lead_cyc  = POS_W'(lead_cycles(code, LEAD_STEP));
   assign pos_next  = cnt_next + lead_cyc;
   assign bit_sel   = pos_next[BIT_SH +: 3];
   assign at_bit    = (pos_next[BIT_SH-1:0] == '0);
   assign last_slot = &pos_next[SLOT_W-1:0];
   assign src_byte  = req_q ? tx_byte : byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q     <= '0;
         ser_q      <= 1'b0;
         req_q      <= 1'b0;
         req_chan_q <= '0;
      end else begin
         req_q      <= last_slot;
         req_chan_q <= pos_next[POS_W-1 -: CH_W] + CH_W'(1);
         if (req_q) byte_q <= tx_byte;
         if (at_bit || frame_pulse) ser_q <= src_byte[~bit_sel];
      end
   end

endmodule

// File: rtl/tdm_out_lead.sv
module tdm_out_lead
   import tdm_lead_pkg::*;
#(
   parameter int N_LCL        = 32,
   parameter int N_BP         = 32,
   parameter int CHANNELS     = 128,
   parameter int CLKS_PER_BIT = 16,
   parameter int LEAD_STEP    = 2,
   localparam int N_MAX       = (N_LCL > N_BP) ? N_LCL : N_BP,
   localparam int IDX_W       = (N_MAX > 1) ? $clog2(N_MAX) : 1,
   localparam int CH_W        = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_pulse,
   input  logic                   cfg_we,
   input  logic                   cfg_bank,
   input  logic [IDX_W-1:0]       cfg_idx,
   input  logic [1:0]             cfg_code,
   input  logic [N_LCL*8-1:0]     lcl_byte,
   input  logic [N_BP*8-1:0]      bp_byte,
   output logic [N_LCL-1:0]       lcl_ser,
   output logic [N_BP-1:0]        bp_ser,
   output logic [N_LCL-1:0]       lcl_req,
   output logic [N_BP-1:0]        bp_req,
   output logic [N_LCL*CH_W-1:0]  lcl_req_chan,
   output logic [N_BP*CH_W-1:0]   bp_req_chan
);

   localparam int BIT_SH = $clog2(CLKS_PER_BIT);
   localparam int POS_W  = CH_W + 3 + BIT_SH;

   if ((1 << BIT_SH) != CLKS_PER_BIT || BIT_SH < 2) begin : g_bad_bit
      $error("CLKS_PER_BIT must be a power of two of at least 4");
   end
   if ((1 << CH_W) != CHANNELS || CHANNELS < 2) begin : g_bad_ch
      $error("CHANNELS must be a power of two of at least 2");
   end
   if (3 * LEAD_STEP >= CLKS_PER_BIT) begin : g_bad_lead
      $error("largest lead must stay below one bit period");
   end
   if (N_LCL < 1 || N_BP < 1) begin : g_bad_n
      $error("each bank needs at least one stream");
   end

   logic [POS_W-1:0]   cnt_q;
   logic [POS_W-1:0]   cnt_next;
   logic [2*N_LCL-1:0] lcl_act_flat;
   logic [2*N_LCL-1:0] lcl_eff_flat;
   logic [2*N_BP-1:0]  bp_act_flat;
   logic [2*N_BP-1:0]  bp_eff_flat;

   tdm_lead_frame_ctr #(.POS_W(POS_W)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_pulse (frame_pulse),
      .cnt_q       (cnt_q),
      .cnt_next    (cnt_next)
   );

   tdm_lead_cfg_bank #(.N(N_LCL), .IDX_W(IDX_W)) u_lcl_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_pulse (frame_pulse),
      .wr_en       (cfg_we && !cfg_bank),
      .wr_idx      (cfg_idx),
      .wr_code     (cfg_code),
      .act_flat    (lcl_act_flat),
      .eff_flat    (lcl_eff_flat)
   );

   tdm_lead_cfg_bank #(.N(N_BP), .IDX_W(IDX_W)) u_bp_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_pulse (frame_pulse),
      .wr_en       (cfg_we && cfg_bank),
      .wr_idx      (cfg_idx),
      .wr_code     (cfg_code),
      .act_flat    (bp_act_flat),
      .eff_flat    (bp_eff_flat)
   );

   for (genvar s = 0; s < N_LCL; s++) begin : g_lcl
      tdm_lead_serializer #(
         .POS_W(POS_W), .BIT_SH(BIT_SH), .CH_W(CH_W), .LEAD_STEP(LEAD_STEP)
      ) u_ser (
         .clk         (clk),
         .rst_n       (rst_n),
         .frame_pulse (frame_pulse),
         .cnt_next    (cnt_next),
         .code        (lcl_eff_flat[2*s +: 2]),
         .tx_byte     (lcl_byte[8*s +: 8]),
         .ser_q       (lcl_ser[s]),
         .req_q       (lcl_req[s]),
         .req_chan_q  (lcl_req_chan[CH_W*s +: CH_W])
      );
   end

   for (genvar s = 0; s < N_BP; s++) begin : g_bp
      tdm_lead_serializer #(
         .POS_W(POS_W), .BIT_SH(BIT_SH), .CH_W(CH_W), .LEAD_STEP(LEAD_STEP)
      ) u_ser (
         .clk         (clk),
         .rst_n       (rst_n),
         .frame_pulse (frame_pulse),
         .cnt_next    (cnt_next),
         .code        (bp_eff_flat[2*s +: 2]),
         .tx_byte     (bp_byte[8*s +: 8]),
         .ser_q       (bp_ser[s]),
         .req_q       (bp_req[s]),
         .req_chan_q  (bp_req_chan[CH_W*s +: CH_W])
      );
   end

endmodule

// File: rtl/tdm_out_lead_chk.sv
module tdm_out_lead_chk #(
   parameter int N_LCL = 32,
   parameter int N_BP  = 32,
   parameter int POS_W = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_pulse,
   input logic [POS_W-1:0]   cnt_q,
   input logic [2*N_LCL-1:0] lcl_act_flat,
   input logic [2*N_BP-1:0]  bp_act_flat,
   input logic [N_LCL-1:0]   lcl_ser,
   input logic [N_BP-1:0]    bp_ser,
   input logic [N_LCL-1:0]   lcl_req,
   input logic [N_BP-1:0]    bp_req
);

   assert_cnt_resync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |=> (cnt_q == '0));

   assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_pulse |=> $stable({lcl_act_flat, bp_act_flat}));

   assert_reset_idle_R5: assert property (@(posedge clk)
      !rst_n |=> ({lcl_act_flat, bp_act_flat} == '0 && lcl_ser == '0 &&
                  bp_ser == '0 && lcl_req == '0 && bp_req == '0));

   for (genvar i = 0; i < N_LCL; i++) begin : g_lcl_req
      assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
         lcl_req[i] |=> !lcl_req[i]);
   end

   for (genvar i = 0; i < N_BP; i++) begin : g_bp_req
      assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
         bp_req[i] |=> !bp_req[i]);
   end

endmodule

bind tdm_out_lead tdm_out_lead_chk #(
   .N_LCL(N_LCL), .N_BP(N_BP), .POS_W(POS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_pulse  (frame_pulse),
   .cnt_q        (cnt_q),
   .lcl_act_flat (lcl_act_flat),
   .bp_act_flat  (bp_act_flat),
   .lcl_ser      (lcl_ser),
   .bp_ser       (bp_ser),
   .lcl_req      (lcl_req),
   .bp_req       (bp_req)
);

// File: tb/tdm_out_lead_bench.sv
module tdm_out_lead_bench;

   localparam int CLK_PERIOD = 8;
   localparam int NL  = 4;
   localparam int NB  = 4;
   localparam int NS  = NL + NB;
   localparam int CH  = 4;
   localparam int CW  = 2;
   localparam int IW  = 2;
   localparam int F   = CH * 128;
   localparam int SEED = 20240611;

   logic clk = 1'b0;
   logic rst_n;
   logic frame_pulse;
   logic cfg_we;
   logic cfg_bank;
   logic [IW-1:0] cfg_idx;
   logic [1:0] cfg_code;
   logic [NL*8-1:0] lcl_byte;
   logic [NB*8-1:0] bp_byte;
   logic [NL-1:0] lcl_ser;
   logic [NB-1:0] bp_ser;
   logic [NL-1:0] lcl_req;
   logic [NB-1:0] bp_req;
   logic [NL*CW-1:0] lcl_req_chan;
   logic [NB*CW-1:0] bp_req_chan;

   logic [7:0] pat [NS][CH];
   int shadow [NS];
   int act [NS];
   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_out_lead #(.N_LCL(NL), .N_BP(NB), .CHANNELS(CH)) u_tdm_out_lead (
      .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
      .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
      .lcl_byte(lcl_byte), .bp_byte(bp_byte),
      .lcl_ser(lcl_ser), .bp_ser(bp_ser), .lcl_req(lcl_req), .bp_req(bp_req),
      .lcl_req_chan(lcl_req_chan), .bp_req_chan(bp_req_chan)
   );

   // Parallel source answers each request with the asked channel's byte.
   always_comb begin
      for (int s = 0; s < NL; s++) lcl_byte[8*s +: 8] = pat[s][lcl_req_chan[CW*s +: CW]];
      for (int s = 0; s < NB; s++) bp_byte[8*s +: 8] = pat[NL+s][bp_req_chan[CW*s +: CW]];
   end

   function automatic int pos_of(int code, int fc);
      return (fc + 2 * code) % F;
   endfunction

   function automatic logic exp_ser(int s, int code, int fc);
      int p = pos_of(code, fc);
      return pat[s][p / 128][7 - ((p / 16) % 8)];
   endfunction

   function automatic logic exp_req(int code, int fc);
      return (pos_of(code, fc) % 128) == 127;
   endfunction

   function automatic int exp_chan(int code, int fc);
      return ((pos_of(code, fc) + 1) % F) / 128;
   endfunction

   function automatic logic ser_of(int s);
      return (s < NL) ? lcl_ser[s] : bp_ser[s-NL];
   endfunction

   function automatic logic req_of(int s);
      return (s < NL) ? lcl_req[s] : bp_req[s-NL];
   endfunction

   function automatic int chan_of(int s);
      return (s < NL) ? int'(lcl_req_chan[CW*s +: CW]) : int'(bp_req_chan[CW*(s-NL) +: CW]);
   endfunction

   task automatic check(string tag, int actual, int expected);
      checks++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int fc;
      int frames;
      bit skip;
      bit r4_frame;
      int wr_n;
      void'($urandom(SEED));
      for (int s = 0; s < NS; s++) begin
         for (int c = 0; c < CH; c++) pat[s][c] = 8'($urandom());
         pat[s][0][7] = 1'b1;     // first bit of frame
         pat[s][CH-1][0] = 1'b0;  // last bit of frame
         shadow[s] = 0;
         act[s] = 0;
      end
      rst_n = 1'b0; frame_pulse = 1'b0; cfg_we = 1'b0;
      cfg_bank = 1'b0; cfg_idx = '0; cfg_code = '0;
      repeat (3) @(negedge clk);
      // R5: idle state under reset
      check("R5 ser idle", int'({lcl_ser, bp_ser}), 0);
      check("R5 req idle", int'({lcl_req, bp_req}), 0);
      rst_n = 1'b1;
      fc = F - 20; frames = 0; skip = 1'b0; r4_frame = 1'b0; wr_n = 0;

      while (frames < 26) begin
         bit on;
         bit early;
         bit do_wr;
         on = (frames >= 2) && !skip;
         if (on) begin
            for (int s = 0; s < NS; s++) begin
               string tag;
               int p;
               if (r4_frame)               tag = "R4";
               else if (shadow[s] != act[s]) tag = "R6";
               else if (frames < 4)        tag = "R5";
               else if (frames < 7)        tag = "R1";
               else                        tag = "R2";
               check($sformatf("%s ser s%0d fc%0d", tag, s, fc),
                     ser_of(s), exp_ser(s, act[s], fc));
               check($sformatf("R7 req s%0d fc%0d", s, fc), req_of(s), exp_req(act[s], fc));
               if (exp_req(act[s], fc))
                  check($sformatf("R7 chan s%0d", s), chan_of(s), exp_chan(act[s], fc));
               p = pos_of(act[s], fc);
               if (p == 0)     check($sformatf("R3 first bit s%0d code%0d", s, act[s]), ser_of(s), 1);
               if (p == F - 1) check($sformatf("R3 prior bit s%0d code%0d", s, act[s]), ser_of(s), 0);
            end
         end
         // inputs for the coming edge
         early = (frames == 21) && (fc == 200);
         frame_pulse = (fc == F - 1) || early;
         do_wr = 1'b0;
         if (!frame_pulse) begin
            if (frames == 4 && fc >= 5 && fc < 5 + NS) begin
               do_wr = 1'b1;
               wr_n = fc - 5;
               cfg_bank = (wr_n >= NL);
               cfg_idx = IW'(cfg_bank ? wr_n - NL : wr_n);
               cfg_code = 2'(cfg_bank ? 3 - (wr_n - NL) : wr_n);
            end else if (frames >= 7 && frames <= 20 && ($urandom() % 150) == 0) begin
               do_wr = 1'b1;
               cfg_bank = 1'($urandom());
               cfg_idx = IW'($urandom());
               cfg_code = 2'($urandom());
            end
         end
         cfg_we = do_wr;
         @(posedge clk);
         if (frame_pulse) begin
            for (int s = 0; s < NS; s++) act[s] = shadow[s];
            fc = 0;
            frames++;
            r4_frame = skip;
            skip = early;
         end else begin
            fc = (fc + 1) % F;
         end
         if (do_wr) shadow[cfg_bank ? NL + int'(cfg_idx) : int'(cfg_idx)] = int'(cfg_code);
         @(negedge clk);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule